// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Receiver

This block is the device-side end of a three-wire programming port made of a serial clock line, a serial data line and a latch-enable line. A single system clock samples all three lines through two-flop synchronizers and finds their edges. While latch enable is low, each rising edge of the serial clock moves one data bit into a 32-bit shift register, most significant bit first. When latch enable rises, the word is committed, but only if exactly 32 bits arrived. Its lowest four bits select one of sixteen 28-bit configuration registers, and its upper 28 bits become that register's contents. All registers are visible at all times on one flat parallel output bus.

Two register addresses have side effects. Committing a word to the last register (address 15) raises a calibration-start pulse for one system clock. A word to address 0 that has bit 31 set is a soft reset. It returns every register to its default value and discards the rest of that word. A commit after a bit count other than 32 is dropped and sets a sticky framing-error flag.

A small state machine drives the commit. Its states are HOLD (latch high, idle), SHIFT (latch low, bits being gathered), COMMIT (one cycle that writes, soft-resets and pulses calibration) and DROP (one cycle that discards a bad word). The transitions are: HOLD to SHIFT when latch enable is seen low. SHIFT to COMMIT on a latch-enable rise with a count of 32. SHIFT to DROP on a latch-enable rise with any other count. From COMMIT or DROP, the machine returns to HOLD, or to SHIFT if latch enable is already low again.

Top module: `serial_cfg_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, every register output holds its default value from the `DEFAULTS` parameter (register i at bits i*28 upward), and `cal_start` and `frame_err` are 0.
- R2: Data is sampled at each synchronized rising edge of `ser_clk`, most significant bit first. Word bits [3:0] are the register address and bits [31:4] are the data stored.
- R3: Bits are gathered only while `ser_latch` is low. Any `ser_clk` edges while it is high are ignored, and the bit count is cleared while it is high.
- R4: A `ser_latch` rise after exactly 32 bits writes the data field to the addressed register. The output changes on the fourth system clock edge, counting the edge that first samples `ser_latch` high. All other registers keep their values.
- R5: A committed word to address 15 raises `cal_start` for exactly one system clock. It is high between the third and fourth edges counted as in R4. No other commit raises it.
- R6: A committed word to address 0 with bit 31 set returns all sixteen registers to their defaults. The other bits of that word are ignored and `cal_start` stays low.
- R7: A `ser_latch` rise after fewer or more than 32 bits changes no register. It sets `frame_err` on the same edge at which a good word would have been written, and `frame_err` then stays 1 until `rst_n` is asserted.
- R8: A word to address 0 with bit 31 clear is an ordinary write to register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Latch enable; low while shifting, rising edge commits |
| cfg_regs | output | NREG*(WORD_W-ADDR_W) = 448 | All configuration registers, register i at bits [i*28 +: 28] |
| cal_start | output | 1 | One-clock calibration-start pulse after a commit to address 15 |
| frame_err | output | 1 | Sticky flag for a word of the wrong length |

## Verification
A wrong bit count or a misordered shift register shows up as a wrong value on `cfg_regs`, or as a spurious `frame_err`, on the fourth clock after the latch rises. A state machine stuck in COMMIT or DROP shows up as `cal_start` lasting longer than one clock, or as registers changing with no word sent. Registers are compared with the bench model on every clock, so a write that lands in the wrong register, a wrong default, or a soft reset that skips a register is seen within one clock of the commit.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

    // Commit state machine encoding
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,   // latch high, waiting for a new word
        ST_SHIFT  = 2'd1,   // latch low, bits being gathered
        ST_COMMIT = 2'd2,   // one cycle: write / soft reset / calibration pulse
        ST_DROP   = 2'd3    // one cycle: discard a malformed word
    } rx_state_e;

endpackage

// File: rtl/cfgrx_sync.sv
// Two-flop synchronizers for N lines; the first EDGE_N lines also get a
// rising-edge detector built from a third flop.
module cfgrx_sync #(
    parameter int           N       = 3,
    parameter int           EDGE_N  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      raw_i,
    output logic [N-1:0]      lvl_o,
    output logic [EDGE_N-1:0] rise_o
);

    logic [N-1:0] meta_q;
    logic [N-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= raw_i;
            stab_q <= meta_q;
        end
    end

    assign lvl_o = stab_q;

    for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= RST_VAL[g];
            else        prev_q <= stab_q[g];
        end
        assign rise_o[g] = stab_q[g] & ~prev_q;
    end

endmodule

// File: rtl/cfgrx_shift.sv
// Shift register and saturating bit counter for one serial word.
module cfgrx_shift #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_lvl_i,
    input  logic              sclk_rise_i,
    input  logic              sdat_lvl_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  cnt_o
);

    // One past a full word: enough to tell "too many" from "exactly full"
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
            cnt_o  <= '0;
        end else if (latch_lvl_i) begin
            cnt_o  <= '0;
        end else if (sclk_rise_i) begin
            word_o <= {word_o[WORD_W-2:0], sdat_lvl_i};
            if (cnt_o != CNT_SAT) cnt_o <= cnt_o + 1'b1;
        end
    end

    // Counter is held clear while latch is high
    assert_clear_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_lvl_i |=> (cnt_o == '0));

    // Counter never runs past the saturation point
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_SAT);

endmodule

// File: rtl/cfgrx_ctrl.sv
// Commit state machine: decides write, soft reset, drop and calibration pulse.
module cfgrx_ctrl
    import cfgrx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 4,
    parameter int LAST_ADDR = 15,
    localparam int CNT_W    = $clog2(WORD_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_lvl_i,
    input  logic              latch_rise_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rst_bit_i,
    output logic              wr_en_o,
    output logic              soft_rst_o,
    output logic              cal_start_o,
    output logic              err_o
);

    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(WORD_W);
    localparam logic [ADDR_W-1:0] CAL_ADDR = ADDR_W'(LAST_ADDR);
    localparam logic [ADDR_W-1:0] RST_ADDR = '0;

    rx_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (!latch_lvl_i) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (latch_rise_i)
                    state_d = (cnt_i == FULL_CNT) ? ST_COMMIT : ST_DROP;
            end
            ST_COMMIT, ST_DROP: begin
                state_d = latch_lvl_i ? ST_HOLD : ST_SHIFT;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Output decode from the state register
    always_comb begin
        wr_en_o     = 1'b0;
        soft_rst_o  = 1'b0;
        cal_start_o = 1'b0;
        unique case (state_q)
            ST_COMMIT: begin
                if (addr_i == RST_ADDR && rst_bit_i) soft_rst_o = 1'b1;
                else                                 wr_en_o    = 1'b1;
                if (addr_i == CAL_ADDR)              cal_start_o = 1'b1;
            end
            ST_HOLD, ST_SHIFT, ST_DROP: ;
            default: ;
        endcase
    end

    // Sticky framing error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 err_o <= 1'b0;
        else if (state_q == ST_DROP) err_o <= 1'b1;
    end

    assert_commit_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_COMMIT) |-> (cnt_i == FULL_CNT));

    assert_cal_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start_o |=> !cal_start_o);

    assert_drop_sets_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |=> err_o);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/cfgrx_regbank.sv
// Configuration register bank with per-register defaults.
module cfgrx_regbank #(
    parameter int NREG   = 16,
    parameter int DW     = 28,
    parameter int ADDR_W = 4,
    parameter logic [NREG*DW-1:0] DEFAULTS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               soft_rst_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DW-1:0]      data_i,
    output logic [NREG*DW-1:0] regs_o
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(r);
        logic [DW-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               val_q <= DEFAULTS[r*DW +: DW];
            else if (soft_rst_i)                      val_q <= DEFAULTS[r*DW +: DW];
            else if (wr_en_i && addr_i == MY_ADDR)    val_q <= data_i;
        end

        assign regs_o[r*DW +: DW] = val_q;
    end

    assert_soft_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (regs_o == DEFAULTS));

    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !soft_rst_i) |=> $stable(regs_o));

endmodule

// File: rtl/serial_cfg_rx.sv
// Three-wire serial configuration receiver: top level.
module serial_cfg_rx #(
    parameter int NREG      = 16,
    parameter int ADDR_W    = 4,
    parameter int WORD_W    = 32,
    parameter int LAST_ADDR = 15,
    parameter logic [NREG*(WORD_W-ADDR_W)-1:0] DEFAULTS = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ser_clk,
    input  logic                              ser_dat,
    input  logic                              ser_latch,
    output logic [NREG*(WORD_W-ADDR_W)-1:0]   cfg_regs,
    output logic                              cal_start,
    output logic                              frame_err
);

    localparam int DW    = WORD_W - ADDR_W;
    localparam int CNT_W = $clog2(WORD_W + 2);

    // Line order: 0 = serial clock, 1 = latch enable, 2 = data
    localparam logic [2:0] SYNC_RST = 3'b010;

    logic [2:0]        lvl;
    logic [1:0]        rise;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  cnt;
    logic              wr_en, soft_rst;

    cfgrx_sync #(
        .N       (3),
        .EDGE_N  (2),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({ser_dat, ser_latch, ser_clk}),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    cfgrx_shift #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_lvl_i (lvl[1]),
        .sclk_rise_i (rise[0]),
        .sdat_lvl_i  (lvl[2]),
        .word_o      (word),
        .cnt_o       (cnt)
    );

    cfgrx_ctrl #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .LAST_ADDR (LAST_ADDR)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_lvl_i  (lvl[1]),
        .latch_rise_i (rise[1]),
        .cnt_i        (cnt),
        .addr_i       (word[ADDR_W-1:0]),
        .rst_bit_i    (word[WORD_W-1]),
        .wr_en_o      (wr_en),
        .soft_rst_o   (soft_rst),
        .cal_start_o  (cal_start),
        .err_o        (frame_err)
    );

    cfgrx_regbank #(
        .NREG     (NREG),
        .DW       (DW),
        .ADDR_W   (ADDR_W),
        .DEFAULTS (DEFAULTS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .soft_rst_i (soft_rst),
        .addr_i     (word[ADDR_W-1:0]),
        .data_i     (word[WORD_W-1:ADDR_W]),
        .regs_o     (cfg_regs)
    );

    // Calibration pulse and soft reset never coincide (different addresses)
    assert_cal_not_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_start && soft_rst));

endmodule

// File: tb/test_serial_cfg_rx.sv
module test_serial_cfg_rx;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 16;
    localparam int DW   = 28;
    localparam logic [NREG*DW-1:0] DEF =
        {28'h1234567, {11{28'h0}}, 28'h00ABCDE, {3{28'h0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_latch = 1'b1;
    logic [NREG*DW-1:0] cfg_regs;
    logic cal_start, frame_err;

    int checks = 0;
    int errors = 0;
    int cal_seen = 0;
    int cyc = 0;
    bit done = 0;

    serial_cfg_rx #(.DEFAULTS(DEF)) i_serial_cfg_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .cfg_regs(cfg_regs),
        .cal_start(cal_start), .frame_err(frame_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_regs [NREG];
    bit m_cal, m_err;
    bit p_wr, p_soft, p_err;
    int p_idx;
    logic [DW-1:0] p_data;
    bit h_sc [3];
    bit h_le [3];
    bit h_sd [3];
    bit bits_q [$];

    function automatic logic [DW-1:0] def_of(input int i);
        return DEF[i*DW +: DW];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) m_regs[i] = def_of(i);
            m_cal = 0; m_err = 0;
            p_wr = 0; p_soft = 0; p_err = 0; p_idx = 0; p_data = '0;
            for (int i = 0; i < 3; i++) begin h_sc[i] = 0; h_le[i] = 1; h_sd[i] = 0; end
            bits_q.delete();
        end else begin
            m_cal = 0;
            if (p_wr)   m_regs[p_idx] = p_data;
            if (p_soft) for (int i = 0; i < NREG; i++) m_regs[i] = def_of(i);
            if (p_err)  m_err = 1;
            p_wr = 0; p_soft = 0; p_err = 0;
            if (h_le[1] && !h_le[2]) begin
                if (bits_q.size() == 32) begin
                    logic [31:0] w;
                    for (int i = 0; i < 32; i++) w[31-i] = bits_q[i];
                    if (w[3:0] == 4'd0 && w[31]) p_soft = 1;
                    else begin p_wr = 1; p_idx = int'(w[3:0]); p_data = w[31:4]; end
                    if (w[3:0] == 4'd15) m_cal = 1;
                end else begin
                    p_err = 1;
                end
            end
            if (h_le[1]) bits_q.delete();
            else if (h_sc[1] && !h_sc[2]) bits_q.push_back(h_sd[1]);
            h_sc[2] = h_sc[1]; h_sc[1] = h_sc[0]; h_sc[0] = ser_clk;
            h_le[2] = h_le[1]; h_le[1] = h_le[0]; h_le[0] = ser_latch;
            h_sd[2] = h_sd[1]; h_sd[1] = h_sd[0]; h_sd[0] = ser_dat;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NREG; i++) begin
                checks++;
                if (cfg_regs[i*DW +: DW] !== m_regs[i]) begin
                    errors++;
                    $display("FAIL R4 reg %0d actual %h expected %h", i, cfg_regs[i*DW +: DW], m_regs[i]);
                end
            end
            checks++;
            if (cal_start !== m_cal) begin
                errors++;
                $display("FAIL R5 cal_start actual %b expected %b", cal_start, m_cal);
            end
            checks++;
            if (frame_err !== m_err) begin
                errors++;
                $display("FAIL R7 frame_err actual %b expected %b", frame_err, m_err);
            end
            if (cal_start) cal_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R4 watchdog actual %0d cycles expected below 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; ser_clk = 0; ser_dat = 0; ser_latch = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] val, input int n);
        @(negedge clk);
        ser_latch = 0;
        repeat (3) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = val[i]; ser_clk = 0;
            repeat (2) @(negedge clk);
            ser_clk = 1;
            repeat (2) @(negedge clk);
        end
        ser_clk = 0;
        repeat (2) @(negedge clk);
        ser_latch = 1;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [31:0] reg_of(input int i);
        return {4'h0, cfg_regs[i*DW +: DW]};
    endfunction

    initial begin
        int c0;
        do_reset();
        // R1: defaults and idle flags after reset
        chk("R1 reg3 default", reg_of(3), {4'h0, def_of(3)});
        chk("R1 reg15 default", reg_of(15), {4'h0, def_of(15)});
        chk("R1 reg0 default", reg_of(0), 32'h0);
        chk("R1 flags", {30'h0, cal_start, frame_err}, 32'h0);

        // R2: MSB-first word, address in low bits
        c0 = cal_seen;
        send_bits({32'h0, 28'hA5A5A5A, 4'd5}, 32);
        chk("R2 reg5 write", reg_of(5), 32'h0A5A5A5A);
        chk("R5 no pulse on reg5", cal_seen - c0, 0);

        // R4: another register, earlier one untouched
        send_bits({32'h0, 28'h0C3C3C3, 4'd1}, 32);
        chk("R4 reg1 write", reg_of(1), 32'h00C3C3C3);
        chk("R4 reg5 kept", reg_of(5), 32'h0A5A5A5A);

        // R3: serial clock edges while latch high are ignored
        ser_dat = 1;
        for (int k = 0; k < 6; k++) begin
            ser_clk = 1; repeat (2) @(negedge clk);
            ser_clk = 0; repeat (2) @(negedge clk);
        end
        chk("R3 regs untouched", reg_of(2), 32'h0);
        send_bits({32'h0, 28'h1357BDF, 4'd2}, 32);
        chk("R3 reg2 after idle clocks", reg_of(2), 32'h01357BDF);
        chk("R3 no error", {31'h0, frame_err}, 32'h0);

        // R5: last register starts calibration with one pulse
        c0 = cal_seen;
        send_bits({32'h0, 28'h0FEDCBA, 4'd15}, 32);
        chk("R5 reg15 write", reg_of(15), 32'h00FEDCBA);
        chk("R5 single pulse", cal_seen - c0, 1);

        // R8: reg0 with reset bit clear is a normal write
        send_bits({32'h0, 28'h7FFFFFF, 4'd0}, 32);
        chk("R8 reg0 write", reg_of(0), 32'h07FFFFFF);

        // R6: reset bit returns all registers to defaults
        c0 = cal_seen;
        send_bits({32'h0, 28'h8765432, 4'd0}, 32);
        chk("R6 reg0 default", reg_of(0), 32'h0);
        chk("R6 reg5 default", reg_of(5), 32'h0);
        chk("R6 reg15 default", reg_of(15), {4'h0, def_of(15)});
        chk("R6 reg3 default", reg_of(3), {4'h0, def_of(3)});
        chk("R6 no pulse", cal_seen - c0, 0);

        // R7: short word dropped, error sticky
        send_bits({32'h0, 28'h0000111, 4'd6}, 31);
        chk("R7 short reg6 kept", reg_of(6), 32'h0);
        chk("R7 short err", {31'h0, frame_err}, 32'h1);
        send_bits({32'h0, 28'h0000222, 4'd7}, 32);
        chk("R7 good write after err", reg_of(7), 32'h00000222);
        chk("R7 err sticky", {31'h0, frame_err}, 32'h1);

        do_reset();
        chk("R1 err cleared", {31'h0, frame_err}, 32'h0);
        chk("R1 reg7 default", reg_of(7), 32'h0);

        // R7: long word dropped
        send_bits({31'h0, 1'b1, 28'h0999999, 4'd9}, 33);
        chk("R7 long reg9 kept", reg_of(9), 32'h0);
        chk("R7 long err", {31'h0, frame_err}, 32'h1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule